// File: doc/BRIEF.md
# Double-Buffered Reference Channel Register File

This block sits behind a two-wire serial slave front end and turns its byte stream into register traffic for a bank of programmable reference channels. It holds sixteen gamma channels and two common-voltage channels. Each channel has an input register, which the serial writes fill, and an output register, which drives the converter. In a write transaction the first byte is a pointer byte. Its top two bits pick a register access, a general acquire or a single-channel acquire, and its low six bits give an address. Pairs of data bytes follow, most significant byte first. A pair is committed only when its second byte arrives, and the pointer then steps to the next address.

Bit 15 of a data word can also load every output register from its input register in one step. This lets a full curve be staged while the converter outputs stay unchanged. A word whose top two bits are `01` is a program request for the nonvolatile store. Reads return channel output values, or the identification, revision and write-count registers. Acquire and program requests go out to a separate nonvolatile controller as single-cycle pulses. That controller writes recalled values back through a load port. A power-up or a general-call reset returns the block to its default state and asks for a general acquire.

Top module: `gbuf_regfile`

## Requirements
- R1: After reset every channel's input and output registers hold `RST_CODE` (default 0x200), and `acq_all_req` pulses exactly once.
- R2: A pointer byte with bits 7:6 = `10`, closed by `frm_end` with no data byte after it, pulses `acq_all_req`. With bits 7:6 = `01` it pulses `acq_one_req`, and `acq_addr` equals the pointer bits 5:0. Bits 7:6 = `00` select a plain register access.
- R3: A channel's input register changes only on the second (low) byte of a word. A `frm_end` between the two bytes leaves it unchanged.
- R4: A register write with data bit 15 = 0 changes only the input register. With bit 15 = 1, every channel's output register loads its input value, including this word's value, in the cycle after the low byte.
- R5: After each complete word the pointer advances by one. Addresses 0–15 are the gamma channels, 18–19 the common-voltage channels, and the words sent to addresses 16–17 are discarded while still advancing the pointer.
- R6: A read returns the channel output value in bits 9:0 with bits 15:10 zero, high byte first. Addresses 16, 17 and 20–59 read as zero.
- R7: Address 61 returns `ID_VAL`, 60 returns `REV_VAL` and 63 returns the write-count register, but only as the first word of a read transaction. Later words in the same read return zero.
- R8: A word with bits 15:14 = `01`, sent as the only word of a register-access transaction, pulses `prog_req` at `frm_end` with `prog_addr`/`prog_data`, and loads that channel's input and output registers. Any further data byte cancels it, and the program word itself is stored nowhere.
- R9: `nv_ld_vld` loads both registers of the addressed channel, and an address with no channel changes nothing. `wc_vld` loads the write-count register.
- R10: `gc_reset` returns all channels to `RST_CODE`, clears the write count and the pointer, and pulses `acq_all_req` once.
- R11: Data words that follow an acquire-type pointer byte write nothing and suppress the acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gc_reset | input | 1 | General-call reset strobe |
| frm_begin | input | 1 | Write transaction addressed to this block begins |
| frm_read | input | 1 | Read transaction addressed to this block begins |
| frm_end | input | 1 | Stop or repeated start seen |
| byte_vld | input | 1 | Received write byte valid |
| byte_in | input | 8 | Received write byte |
| rd_take | input | 1 | Current read byte has been shifted out |
| rd_byte | output | 8 | Byte presented for the next read slot |
| nv_ld_vld | input | 1 | Nonvolatile controller loads a channel |
| nv_ld_addr | input | 6 | Channel address for the load |
| nv_ld_data | input | DW | Value for the load |
| wc_vld | input | 1 | Write-count update strobe |
| wc_in | input | WC_W | Write-count value |
| acq_all_req | output | 1 | General acquire request pulse |
| acq_one_req | output | 1 | Single-channel acquire request pulse |
| acq_addr | output | 6 | Address for single acquire |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | 6 | Address to program |
| prog_data | output | DW | Value to program |
| chan_out | output | (N_GAM+N_COM)*DW | Output registers, channel 0 in the low bits |

## Verification
The bench builds the block with the default map: ten-bit values, sixteen gamma channels and two common-voltage channels placed at 18. It therefore covers the real reserved gap at 16–17 and the hole between 20 and 59. The identification and revision parameters are overridden with asymmetric values (0xA5C3 and 0x0002). This makes byte order and the first-word-only rule visible on `rd_byte`. The reset code is left at midscale, so channels never written since reset can be told apart from channels written with zero.

// File: rtl/gbuf_pkg.sv
package gbuf_pkg;
   localparam int PTR_W = 6;
   typedef logic [PTR_W-1:0] ptr_t;

   typedef enum logic [1:0] {
      CMD_REG = 2'b00,
      CMD_ONE = 2'b01,
      CMD_ALL = 2'b10,
      CMD_RSV = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PTR,
      PH_MSB,
      PH_LSB
   } wph_e;

   localparam logic [1:0] KIND_PROG = 2'b01;
   localparam ptr_t A_REV  = 6'h3C;
   localparam ptr_t A_ID   = 6'h3D;
   localparam ptr_t A_WCNT = 6'h3F;

   // channel index -> pointer address: gamma first, then common-voltage block
   function automatic ptr_t chan_addr(int idx, int n_gam, int com_base);
      int a;
      a = (idx < n_gam) ? idx : com_base + idx - n_gam;
      return ptr_t'(a);
   endfunction
endpackage

// File: rtl/gbuf_seq.sv
module gbuf_seq
   import gbuf_pkg::*;
#(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gc_reset,
   input  logic          frm_begin,
   input  logic          frm_read,
   input  logic          frm_end,
   input  logic          byte_vld,
   input  logic [7:0]    byte_in,
   input  logic          rd_take,
   output ptr_t          ptr,
   output logic          rd_half,
   output logic          rd_first,
   output logic          wr_en,
   output logic [DW-1:0] wr_data,
   output logic          load_all,
   output logic          pg_en,
   output ptr_t          pg_addr,
   output logic [DW-1:0] pg_data,
   output logic          acq_all_req,
   output logic          acq_one_req,
   output ptr_t          acq_addr,
   output logic          prog_req,
   output ptr_t          prog_addr,
   output logic [DW-1:0] prog_data
);
   wph_e          ph_q;
   cmd_e          cmd_q;
   ptr_t          ptr_q;
   logic [7:0]    msb_q;
   logic          any_data_q, done_word_q;
   logic          pend_q;
   ptr_t          pend_addr_q;
   logic [DW-1:0] pend_data_q;
   logic          half_q, first_q, rd_act_q;
   logic          boot_q;
   logic          all_q, one_q, prg_q;
   ptr_t          acq_addr_q, prg_addr_q;
   logic [DW-1:0] prg_data_q;

   logic          quiet, ev_ptr, ev_msb, ev_lsb, is_prog;
   logic          end_ok, only_ptr, fire_all, fire_one, fire_pg, rd_step;
   logic [15:0]   word;

   always_comb begin
      quiet    = !gc_reset && !frm_end && !frm_begin && !frm_read;
      ev_ptr   = byte_vld && quiet && (ph_q == PH_PTR);
      ev_msb   = byte_vld && quiet && (ph_q == PH_MSB);
      ev_lsb   = byte_vld && quiet && (ph_q == PH_LSB);
      word     = {msb_q, byte_in};
      is_prog  = (msb_q[7:6] == KIND_PROG);
      end_ok   = frm_end && !gc_reset;
      only_ptr = (ph_q == PH_MSB) && !any_data_q;
      fire_all = end_ok && only_ptr && (cmd_q == CMD_ALL);
      fire_one = end_ok && only_ptr && (cmd_q == CMD_ONE);
      fire_pg  = end_ok && pend_q;
      rd_step  = rd_take && quiet && rd_act_q;
   end

   assign wr_en     = ev_lsb && (cmd_q == CMD_REG) && !is_prog;
   assign wr_data   = word[DW-1:0];
   assign load_all  = wr_en && msb_q[7];
   assign pg_en     = fire_pg;
   assign pg_addr   = pend_addr_q;
   assign pg_data   = pend_data_q;
   assign ptr       = ptr_q;
   assign rd_half   = half_q;
   assign rd_first  = first_q;
   assign acq_all_req = all_q;
   assign acq_one_req = one_q;
   assign acq_addr    = acq_addr_q;
   assign prog_req    = prg_q;
   assign prog_addr   = prg_addr_q;
   assign prog_data   = prg_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         cmd_q       <= CMD_REG;
         ptr_q       <= '0;
         msb_q       <= '0;
         any_data_q  <= 1'b0;
         done_word_q <= 1'b0;
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
         half_q      <= 1'b0;
         first_q     <= 1'b0;
         rd_act_q    <= 1'b0;
         boot_q      <= 1'b1;
         all_q       <= 1'b0;
         one_q       <= 1'b0;
         prg_q       <= 1'b0;
         acq_addr_q  <= '0;
         prg_addr_q  <= '0;
         prg_data_q  <= '0;
      end else begin
         all_q  <= boot_q || fire_all;
         one_q  <= fire_one;
         prg_q  <= fire_pg;
         boot_q <= 1'b0;
         if (fire_one) acq_addr_q <= ptr_q;
         if (fire_pg) begin
            prg_addr_q <= pend_addr_q;
            prg_data_q <= pend_data_q;
         end
         if (gc_reset) begin
            ph_q     <= PH_IDLE;
            ptr_q    <= '0;
            pend_q   <= 1'b0;
            half_q   <= 1'b0;
            first_q  <= 1'b0;
            rd_act_q <= 1'b0;
            boot_q   <= 1'b1;
         end else if (frm_end) begin
            ph_q     <= PH_IDLE;
            pend_q   <= 1'b0;
            half_q   <= 1'b0;
            first_q  <= 1'b0;
            rd_act_q <= 1'b0;
         end else if (frm_begin) begin
            ph_q        <= PH_PTR;
            pend_q      <= 1'b0;
            any_data_q  <= 1'b0;
            done_word_q <= 1'b0;
            rd_act_q    <= 1'b0;
         end else if (frm_read) begin
            ph_q     <= PH_IDLE;
            half_q   <= 1'b0;
            first_q  <= 1'b1;
            rd_act_q <= 1'b1;
         end else begin
            if (ev_ptr) begin
               ptr_q       <= byte_in[PTR_W-1:0];
               cmd_q       <= cmd_e'(byte_in[7:6]);
               ph_q        <= PH_MSB;
               any_data_q  <= 1'b0;
               done_word_q <= 1'b0;
            end
            if (ev_msb) begin
               msb_q      <= byte_in;
               ph_q       <= PH_LSB;
               any_data_q <= 1'b1;
               pend_q     <= 1'b0;
            end
            if (ev_lsb) begin
               ph_q        <= PH_MSB;
               ptr_q       <= ptr_q + 1'b1;
               done_word_q <= 1'b1;
               if ((cmd_q == CMD_REG) && is_prog && !done_word_q) begin
                  pend_q      <= 1'b1;
                  pend_addr_q <= ptr_q;
                  pend_data_q <= word[DW-1:0];
               end
            end
            if (rd_step) begin
               if (!half_q) begin
                  half_q <= 1'b1;
               end else begin
                  half_q  <= 1'b0;
                  first_q <= 1'b0;
                  ptr_q   <= ptr_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/gbuf_bank.sv
module gbuf_bank
   import gbuf_pkg::*;
#(
   parameter int          DW       = 10,
   parameter int          N_GAM    = 16,
   parameter int          N_COM    = 2,
   parameter int          COM_BASE = 18,
   parameter logic [DW-1:0] RST_CODE = DW'(1) << (DW-1),
   localparam int         NCH      = N_GAM + N_COM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  ptr_t              wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic              load_all,
   input  logic              pg_en,
   input  ptr_t              pg_addr,
   input  logic [DW-1:0]     pg_data,
   input  logic              ld_en,
   input  ptr_t              ld_addr,
   input  logic [DW-1:0]     ld_data,
   output logic [NCH*DW-1:0] out_flat
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam ptr_t ADDR = chan_addr(i, N_GAM, COM_BASE);
      logic [DW-1:0] in_q, out_q;
      logic          hit_w, hit_p, hit_l;

      assign hit_w = wr_en && (wr_addr == ADDR);
      assign hit_p = pg_en && (pg_addr == ADDR);
      assign hit_l = ld_en && (ld_addr == ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q  <= RST_CODE;
            out_q <= RST_CODE;
         end else if (clr) begin
            in_q  <= RST_CODE;
            out_q <= RST_CODE;
         end else if (hit_l) begin
            in_q  <= ld_data;
            out_q <= ld_data;
         end else if (hit_p) begin
            in_q  <= pg_data;
            out_q <= pg_data;
         end else begin
            if (hit_w) in_q <= wr_data;
            if (load_all) out_q <= hit_w ? wr_data : in_q;
         end
      end

      assign out_flat[i*DW +: DW] = out_q;
   end
endmodule

// File: rtl/gbuf_rdmux.sv
module gbuf_rdmux
   import gbuf_pkg::*;
#(
   parameter int          DW       = 10,
   parameter int          N_GAM    = 16,
   parameter int          N_COM    = 2,
   parameter int          COM_BASE = 18,
   parameter int          WC_W     = 4,
   parameter logic [15:0] ID_VAL   = 16'h5927,
   parameter logic [15:0] REV_VAL  = 16'h0000,
   localparam int         NCH      = N_GAM + N_COM
) (
   input  ptr_t              ptr,
   input  logic              half,
   input  logic              first,
   input  logic [NCH*DW-1:0] out_flat,
   input  logic [WC_W-1:0]   wcount,
   output logic [7:0]        rd_byte
);
   logic [15:0] w;

   always_comb begin
      w = '0;
      for (int i = 0; i < NCH; i++) begin
         if (ptr == chan_addr(i, N_GAM, COM_BASE)) w = 16'(out_flat[i*DW +: DW]);
      end
      if (first) begin
         case (ptr)
            A_REV:   w = REV_VAL;
            A_ID:    w = ID_VAL;
            A_WCNT:  w = 16'(wcount);
            default: ;
         endcase
      end
      rd_byte = half ? w[7:0] : w[15:8];
   end
endmodule

// File: rtl/gbuf_regfile.sv
module gbuf_regfile
   import gbuf_pkg::*;
#(
   parameter int            DW       = 10,
   parameter int            N_GAM    = 16,
   parameter int            N_COM    = 2,
   parameter int            COM_BASE = 18,
   parameter int            WC_W     = 4,
   parameter logic [15:0]   ID_VAL   = 16'h5927,
   parameter logic [15:0]   REV_VAL  = 16'h0000,
   parameter logic [DW-1:0] RST_CODE = DW'(1) << (DW-1),
   localparam int           NCH      = N_GAM + N_COM,
   localparam int           CH_W     = NCH * DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gc_reset,
   input  logic            frm_begin,
   input  logic            frm_read,
   input  logic            frm_end,
   input  logic            byte_vld,
   input  logic [7:0]      byte_in,
   input  logic            rd_take,
   output logic [7:0]      rd_byte,
   input  logic            nv_ld_vld,
   input  logic [5:0]      nv_ld_addr,
   input  logic [DW-1:0]   nv_ld_data,
   input  logic            wc_vld,
   input  logic [WC_W-1:0] wc_in,
   output logic            acq_all_req,
   output logic            acq_one_req,
   output logic [5:0]      acq_addr,
   output logic            prog_req,
   output logic [5:0]      prog_addr,
   output logic [DW-1:0]   prog_data,
   output logic [CH_W-1:0] chan_out
);
   if (DW < 9 || DW > 14) begin : g_bad_dw
      $error("gbuf_regfile: DW must lie in 9..14");
   end
   if (N_GAM < 1 || N_GAM > COM_BASE) begin : g_bad_gam
      $error("gbuf_regfile: gamma channels overlap the common-voltage block");
   end
   if (COM_BASE + N_COM > 60) begin : g_bad_com
      $error("gbuf_regfile: channel map reaches the identification registers");
   end
   if (WC_W < 1 || WC_W > 16) begin : g_bad_wc
      $error("gbuf_regfile: WC_W must lie in 1..16");
   end

   ptr_t            ptr_w, pg_addr_w;
   logic            half_w, first_w, wr_en_w, load_all_w, pg_en_w;
   logic [DW-1:0]   wr_data_w, pg_data_w;
   logic [WC_W-1:0] wcount_q;

   gbuf_seq #(.DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .gc_reset   (gc_reset),
      .frm_begin  (frm_begin),
      .frm_read   (frm_read),
      .frm_end    (frm_end),
      .byte_vld   (byte_vld),
      .byte_in    (byte_in),
      .rd_take    (rd_take),
      .ptr        (ptr_w),
      .rd_half    (half_w),
      .rd_first   (first_w),
      .wr_en      (wr_en_w),
      .wr_data    (wr_data_w),
      .load_all   (load_all_w),
      .pg_en      (pg_en_w),
      .pg_addr    (pg_addr_w),
      .pg_data    (pg_data_w),
      .acq_all_req(acq_all_req),
      .acq_one_req(acq_one_req),
      .acq_addr   (acq_addr),
      .prog_req   (prog_req),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data)
   );

   gbuf_bank #(
      .DW(DW), .N_GAM(N_GAM), .N_COM(N_COM), .COM_BASE(COM_BASE), .RST_CODE(RST_CODE)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (gc_reset),
      .wr_en   (wr_en_w),
      .wr_addr (ptr_w),
      .wr_data (wr_data_w),
      .load_all(load_all_w),
      .pg_en   (pg_en_w),
      .pg_addr (pg_addr_w),
      .pg_data (pg_data_w),
      .ld_en   (nv_ld_vld),
      .ld_addr (nv_ld_addr),
      .ld_data (nv_ld_data),
      .out_flat(chan_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wcount_q <= '0;
      else if (gc_reset) wcount_q <= '0;
      else if (wc_vld)   wcount_q <= wc_in;
   end

   gbuf_rdmux #(
      .DW(DW), .N_GAM(N_GAM), .N_COM(N_COM), .COM_BASE(COM_BASE),
      .WC_W(WC_W), .ID_VAL(ID_VAL), .REV_VAL(REV_VAL)
   ) u_rd (
      .ptr     (ptr_w),
      .half    (half_w),
      .first   (first_w),
      .out_flat(chan_out),
      .wcount  (wcount_q),
      .rd_byte (rd_byte)
   );
endmodule

// File: rtl/gbuf_regfile_chk.sv
module gbuf_regfile_chk #(
   parameter int CW     = 180,
   parameter int RSV_LO = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          gc_reset,
   input logic          frm_end,
   input logic          byte_vld,
   input logic          nv_ld_vld,
   input logic [CW-1:0] chan_out,
   input logic          acq_all_req,
   input logic          acq_one_req,
   input logic          prog_req,
   input logic          wr_en,
   input logic [5:0]    ptr,
   input logic [7:0]    rd_byte
);
   // R4: without a byte, end, load or reset the outputs hold
   a_r4_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !frm_end && !nv_ld_vld && !gc_reset) |=> $stable(chan_out));

   // R2: request pulses never overlap
   a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acq_all_req, acq_one_req, prog_req}));

   // R8: program request only follows a transaction end
   a_r8_prog_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(frm_end));

   // R10: general acquire is a single-cycle pulse
   a_r10_acq_single: assert property (@(posedge clk) disable iff (!rst_n)
      acq_all_req |=> !acq_all_req);

   // R3: a commit happens only on a received byte with no end condition
   a_r3_wr_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (byte_vld && !frm_end));

   // R5: every committed word advances the pointer by one
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !gc_reset) |=> (ptr == $past(ptr) + 6'd1));

   // R6: the reserved hole below the identification registers reads zero
   a_r6_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr >= 6'(RSV_LO) && ptr <= 6'd59) |-> (rd_byte == 8'h00));
endmodule

bind gbuf_regfile gbuf_regfile_chk #(.CW(CH_W), .RSV_LO(COM_BASE + N_COM)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gc_reset   (gc_reset),
   .frm_end    (frm_end),
   .byte_vld   (byte_vld),
   .nv_ld_vld  (nv_ld_vld),
   .chan_out   (chan_out),
   .acq_all_req(acq_all_req),
   .acq_one_req(acq_one_req),
   .prog_req   (prog_req),
   .wr_en      (wr_en_w),
   .ptr        (ptr_w),
   .rd_byte    (rd_byte)
);

// File: tb/sim_gbuf_regfile.sv
module sim_gbuf_regfile;
   localparam int DW  = 10;
   localparam int NCH = 18;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            gc_reset = 1'b0, frm_begin = 1'b0, frm_read = 1'b0, frm_end = 1'b0;
   logic            byte_vld = 1'b0, rd_take = 1'b0;
   logic [7:0]      byte_in = '0;
   logic [7:0]      rd_byte;
   logic            nv_ld_vld = 1'b0;
   logic [5:0]      nv_ld_addr = '0;
   logic [DW-1:0]   nv_ld_data = '0;
   logic            wc_vld = 1'b0;
   logic [3:0]      wc_in = '0;
   logic            acq_all_req, acq_one_req, prog_req;
   logic [5:0]      acq_addr, prog_addr;
   logic [DW-1:0]   prog_data;
   logic [NCH*DW-1:0] chan_out;

   int n_run = 0, n_fail = 0;
   int n_all = 0, n_one = 0, n_prog = 0;
   logic [5:0]    seen_acq_addr = '0, seen_prog_addr = '0;
   logic [DW-1:0] seen_prog_data = '0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gbuf_regfile #(.ID_VAL(16'hA5C3), .REV_VAL(16'h0002)) u0 (
      .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .frm_begin(frm_begin),
      .frm_read(frm_read), .frm_end(frm_end), .byte_vld(byte_vld), .byte_in(byte_in),
      .rd_take(rd_take), .rd_byte(rd_byte), .nv_ld_vld(nv_ld_vld), .nv_ld_addr(nv_ld_addr),
      .nv_ld_data(nv_ld_data), .wc_vld(wc_vld), .wc_in(wc_in), .acq_all_req(acq_all_req),
      .acq_one_req(acq_one_req), .acq_addr(acq_addr), .prog_req(prog_req),
      .prog_addr(prog_addr), .prog_data(prog_data), .chan_out(chan_out)
   );

   always @(posedge clk) begin
      if (acq_all_req) n_all <= n_all + 1;
      if (acq_one_req) begin n_one <= n_one + 1; seen_acq_addr <= acq_addr; end
      if (prog_req) begin
         n_prog <= n_prog + 1; seen_prog_addr <= prog_addr; seen_prog_data <= prog_data;
      end
   end

   function automatic logic [DW-1:0] ch(int i);
      return chan_out[i*DW +: DW];
   endfunction

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic put_byte(logic [7:0] b);
      byte_in = b; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
   endtask
   task automatic put_word(logic [15:0] w);
      put_byte(w[15:8]); put_byte(w[7:0]);
   endtask
   task automatic pulse_end;
      frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
   endtask
   task automatic wr_start(logic [7:0] p);
      frm_begin = 1'b1; @(negedge clk); frm_begin = 1'b0;
      put_byte(p);
   endtask
   task automatic rd_start;
      frm_read = 1'b1; @(negedge clk); frm_read = 1'b0;
   endtask
   task automatic take;
      rd_take = 1'b1; @(negedge clk); rd_take = 1'b0;
   endtask
   task automatic read_word(output logic [15:0] w);
      w[15:8] = rd_byte; take();
      w[7:0]  = rd_byte; take();
   endtask

   task automatic t_reset;
      chk("R1 ch0 reset", ch(0), 10'h200);
      chk("R1 ch17 reset", ch(17), 10'h200);
      chk("R1 boot acquire count", n_all, 1);
   endtask

   task automatic t_two_byte;
      wr_start(8'h02); put_byte(8'h01); pulse_end();
      wr_start(8'h03); put_word(16'h8055); pulse_end();
      chk("R3 aborted word not stored", ch(2), 10'h200);
      chk("R4 update-bit word reaches output", ch(3), 10'h055);
   endtask

   task automatic t_update;
      wr_start(8'h00); put_word(16'h0111); put_word(16'h0222); pulse_end();
      chk("R4 bit15=0 output holds ch0", ch(0), 10'h200);
      chk("R4 bit15=0 output holds ch1", ch(1), 10'h200);
      wr_start(8'h05); put_word(16'h83FF); pulse_end();
      chk("R4 load-all ch0", ch(0), 10'h111);
      chk("R4 load-all ch1", ch(1), 10'h222);
      chk("R4 load-all ch5", ch(5), 10'h3FF);
   endtask

   task automatic t_autoinc;
      wr_start(8'd14);
      put_word(16'h00AA); put_word(16'h00BB); put_word(16'h0123);
      put_word(16'h0124); put_word(16'h00CC); put_word(16'h80DD);
      pulse_end();
      chk("R5 ch14", ch(14), 10'h0AA);
      chk("R5 ch15", ch(15), 10'h0BB);
      chk("R5 common 0 skips hole", ch(16), 10'h0CC);
      chk("R5 common 1", ch(17), 10'h0DD);
   endtask

   task automatic t_read;
      logic [15:0] w;
      wr_start(8'd14); pulse_end(); rd_start();
      read_word(w); chk("R6 read ch14", w, 16'h00AA);
      read_word(w); chk("R6 read ch15", w, 16'h00BB);
      read_word(w); chk("R6 reserved 16 zero", w, 16'h0000);
      read_word(w); chk("R6 reserved 17 zero", w, 16'h0000);
      read_word(w); chk("R6 read common 0", w, 16'h00CC);
      pulse_end();
      wr_start(8'd24); pulse_end(); rd_start();
      read_word(w); chk("R6 reserved 24 zero", w, 16'h0000);
      pulse_end();
      wr_start(8'h3D); pulse_end(); rd_start();
      read_word(w); chk("R7 id first word", w, 16'hA5C3);
      read_word(w); chk("R7 addr 62 zero", w, 16'h0000);
      read_word(w); chk("R7 write count not first word", w, 16'h0000);
      pulse_end();
      wr_start(8'h3C); pulse_end(); rd_start();
      read_word(w); chk("R7 revision", w, 16'h0002);
      read_word(w); chk("R7 id in second word zero", w, 16'h0000);
      pulse_end();
   endtask

   task automatic t_acq;
      int a0, o0;
      a0 = n_all; o0 = n_one;
      wr_start(8'h87); pulse_end(); idle(2);
      chk("R2 general acquire", n_all, a0 + 1);
      wr_start(8'h52); pulse_end(); idle(2);
      chk("R2 single acquire", n_one, o0 + 1);
      chk("R2 single acquire address", seen_acq_addr, 6'h12);
      wr_start(8'h43); put_word(16'h8155); pulse_end(); idle(2);
      chk("R11 acquire with data suppressed", n_one, o0 + 1);
      chk("R11 data after acquire not written", ch(3), 10'h055);
   endtask

   task automatic t_prog;
      int p0;
      p0 = n_prog;
      wr_start(8'h09); put_word(16'h42AB); pulse_end();
      chk("R8 program loads channel", ch(9), 10'h2AB);
      idle(2);
      chk("R8 program request", n_prog, p0 + 1);
      chk("R8 program address", seen_prog_addr, 6'h09);
      chk("R8 program data", seen_prog_data, 10'h2AB);
      wr_start(8'h0A); put_word(16'h4111); put_word(16'h0099); pulse_end(); idle(2);
      chk("R8 multi-word program rejected", n_prog, p0 + 1);
      chk("R8 rejected program not stored", ch(10), 10'h200);
   endtask

   task automatic t_nvload;
      logic [15:0] w;
      nv_ld_addr = 6'h13; nv_ld_data = 10'h1EE; nv_ld_vld = 1'b1;
      @(negedge clk); nv_ld_vld = 1'b0;
      chk("R9 load common 1", ch(17), 10'h1EE);
      nv_ld_addr = 6'h10; nv_ld_data = 10'h3AA; nv_ld_vld = 1'b1;
      @(negedge clk); nv_ld_vld = 1'b0;
      chk("R9 load to hole ch15", ch(15), 10'h0BB);
      chk("R9 load to hole ch16", ch(16), 10'h0CC);
      wc_in = 4'hB; wc_vld = 1'b1; @(negedge clk); wc_vld = 1'b0;
      wr_start(8'h3F); pulse_end(); rd_start();
      read_word(w); chk("R9 write count", w, 16'h000B);
      pulse_end();
   endtask

   task automatic t_gc;
      logic [15:0] w;
      int a0;
      wr_start(8'h3D); pulse_end();
      a0 = n_all;
      gc_reset = 1'b1; @(negedge clk); gc_reset = 1'b0;
      idle(3);
      chk("R10 channels cleared", ch(5), 10'h200);
      chk("R10 acquire after reset", n_all, a0 + 1);
      rd_start();
      read_word(w); chk("R10 pointer cleared", w, 16'h0200);
      pulse_end();
      wr_start(8'h3F); pulse_end(); rd_start();
      read_word(w); chk("R10 write count cleared", w, 16'h0000);
      pulse_end();
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_two_byte();
      t_update();
      t_autoinc();
      t_read();
      t_acq();
      t_prog();
      t_nvload();
      t_gc();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule